// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block raises a periodic flag, and optionally an interrupt request, once a chosen number of rising edges has come in from one of two slow timing sources. One source is an external reference clock. The other is a low-power internal clock. A single 8-bit control/status register sets up the block. In that register, a select bit picks the source, an enable bit gates the interrupt request, and a 3-bit rate code sets the period as a power of two. Rate code zero switches the timer off.

A power-mode input decides which source may advance the period counter. In run and wait modes only the external source can advance it, so selecting the internal source freezes the timer. In stop mode only the internal source can advance it, so the timer can serve as a wakeup source while the rest of the chip sleeps. Software clears a pending flag by writing a 1 to the acknowledge bit. The clock source can be changed while the timer runs; the counter restarts and needs no other setup.

Both slow sources are sampled into the bus clock through synchronizer chains. An edge detector on each chain produces a one-cycle tick. The flag, the register and the interrupt request all live in the bus clock domain.

Top module: `wakeTimer`

## Requirements
- R1: After reset the register reads 0x00 and `irq` is low.
- R2: The register reads as {flag[7], 0[6], srcSel[5], intEn[4], 0[3], rate[2:0]}. Bits 6 and 3 always read 0. srcSel=1 selects the internal source and srcSel=0 selects the external one.
- R3: With rate k in 1..7, the flag sets on the 2^(BASE_LOG2+k)-th counted rising edge of the active source after a restart, and counting then continues from zero.
- R4: Rate code 0 disables the timer. The counter is held at zero and the flag never sets, whatever edges arrive.
- R5: In run (powerMode=00) and wait (01) modes, only external edges advance the counter, and only while srcSel=0. With srcSel=1 in these modes the counter is frozen.
- R6: In stop mode (powerMode bit 1 set), only internal edges advance the counter, and only while srcSel=1. With srcSel=0 in stop mode the counter is frozen.
- R7: A register write with bit 6 set clears the flag while the other fields are written as usual. An expiry in the same cycle takes precedence and leaves the flag set.
- R8: `irq` is high exactly when the flag and intEn are both 1.
- R9: A write that changes rate or srcSel restarts the counter from zero. A write that leaves both fields unchanged does not disturb the count.
- R10: Once set, the flag stays set through further periods until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| powerMode | input | 2 | 00 run, 01 wait, 1x stop |
| extClk | input | 1 | External reference clock (asynchronous) |
| intClk | input | 1 | Internal low-power clock (asynchronous) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with BASE_LOG2=0 and SYNC_STAGES=2. With those values rate code 1 expires after two source edges and rate code 7 after 128, so every rate, including the longest period, can be reached edge by edge in a short run. This also makes the counter restart and the no-restart case visible after a single edge. Each source edge is held for several bus cycles, so every expected register value is fixed once the synchronizer and counter have settled.

// File: rtl/wakeTimerPkg.sv
package wakeTimerPkg;

  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int SEL_BIT  = 5;
  localparam int IEN_BIT  = 4;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_WAIT  = 2'b01,
    PM_STOP  = 2'b10,
    PM_STOPX = 2'b11
  } powerMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       countEn;     // selected source is allowed in this power mode
    logic       prescClear;  // hold or restart the prescaler at zero
    logic       srcInternal; // 1: internal source ticks are used
    logic [2:0] rate;        // current rate code
  } wakeStrobe_t;

endpackage

// File: rtl/wakeTimerDatapath.sv
module wakeTimerDatapath
  import wakeTimerPkg::*;
#(
  parameter int BASE_LOG2   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extClk,
  input  logic        intClk,
  input  wakeStrobe_t strobe,
  output logic        expirePulse
);

  localparam int CNT_W   = BASE_LOG2 + 7;
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] srcRaw;
  logic [NUM_SRC-1:0] srcEdge;

  assign srcRaw = {intClk, extClk};

  // one synchronizer chain plus edge detector per source
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-1:0], srcRaw[s]};
    end
    assign srcEdge[s] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  end

  logic             tick;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastCount;

  assign tick      = strobe.srcInternal ? srcEdge[1] : srcEdge[0];
  // BASE_LOG2+rate low bits set: period of 2^(BASE_LOG2+rate) ticks
  assign lastCount = {CNT_W{1'b1}} >> (3'd7 - strobe.rate);

  assign expirePulse = tick && strobe.countEn && (strobe.rate != 3'd0)
                       && (count == lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.prescClear) begin
      count <= '0;
    end else if (tick && strobe.countEn) begin
      if (expirePulse) count <= '0;
      else             count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/wakeTimerCtrl.sv
module wakeTimerCtrl
  import wakeTimerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic [1:0]  powerMode,
  input  logic        expirePulse,
  output wakeStrobe_t strobe,
  output logic [7:0]  rdData,
  output logic        irq
);

  logic       srcSel;
  logic       intEn;
  logic [2:0] rate;
  logic       flag;
  logic       cfgChange;
  logic       inStop;

  assign inStop    = powerMode[1];
  assign cfgChange = wrEn && ((wrData[SEL_BIT] != srcSel) || (wrData[2:0] != rate));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel <= 1'b0;
      intEn  <= 1'b0;
      rate   <= 3'd0;
    end else if (wrEn) begin
      srcSel <= wrData[SEL_BIT];
      intEn  <= wrData[IEN_BIT];
      rate   <= wrData[2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         flag <= 1'b0;
    else if (expirePulse)              flag <= 1'b1;
    else if (wrEn && wrData[ACK_BIT])  flag <= 1'b0;
  end

  always_comb begin
    strobe.countEn     = inStop ? srcSel : !srcSel;
    strobe.prescClear  = (rate == 3'd0) || cfgChange;
    strobe.srcInternal = srcSel;
    strobe.rate        = rate;
  end

  assign rdData = {flag, 1'b0, srcSel, intEn, 1'b0, rate};
  assign irq    = flag & intEn;

endmodule

// File: rtl/wakeTimer.sv
module wakeTimer
  import wakeTimerPkg::*;
#(
  parameter int BASE_LOG2   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [1:0] powerMode,
  input  logic       extClk,
  input  logic       intClk,
  output logic       irq
);

  wakeStrobe_t strobe;
  logic        expirePulse;

  wakeTimerCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .powerMode(powerMode), .expirePulse(expirePulse),
    .strobe(strobe), .rdData(rdData), .irq(irq)
  );

  wakeTimerDatapath #(.BASE_LOG2(BASE_LOG2), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .extClk(extClk), .intClk(intClk),
    .strobe(strobe), .expirePulse(expirePulse)
  );

endmodule

// File: rtl/wakeTimerChecker.sv
module wakeTimerChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [1:0] powerMode,
  input logic       irq,
  input logic       expirePulse
);

  p_resvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[6] == 1'b0) && (rdData[3] == 1'b0));

  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rdData[7] && rdData[4]));

  p_irq_when_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && rdData[4]) |-> irq);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[6] && !expirePulse) |=> !rdData[7]);

  p_expire_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |=> rdData[7]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && !(wrEn && wrData[6])) |=> rdData[7]);

  p_off_no_expire_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2:0] == 3'd0) |-> !expirePulse);

  // R5 and R6: source allowed by power mode
  p_mode_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |-> (powerMode[1] ? rdData[5] : !rdData[5]));

endmodule

bind wakeTimer wakeTimerChecker u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .powerMode(powerMode), .irq(irq), .expirePulse(expirePulse)
);

// File: tb/test_wakeTimer.sv
module test_wakeTimer;

  localparam int BASE_LOG2 = 0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [1:0] powerMode = 2'b00;
  logic       extClk = 1'b0;
  logic       intClk = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] expReg;
    logic       expIrq;
    string      tag;
  } expItem_t;

  expItem_t sbQueue[$];

  always #2 clk = ~clk;  // 250 MHz

  wakeTimer #(.BASE_LOG2(BASE_LOG2), .SYNC_STAGES(2)) i_wakeTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .powerMode(powerMode), .extClk(extClk), .intClk(intClk), .irq(irq)
  );

  function automatic int periodOf(int rate);
    return 1 << (BASE_LOG2 + rate);
  endfunction

  // monitor: compare against expected items away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQueue.size() > 0) begin
        expItem_t it;
        it = sbQueue.pop_front();
        checks++;
        if (rdData !== it.expReg || irq !== it.expIrq) begin
          errors++;
          $display("FAIL %s: rdData=%h expected %h, irq=%b expected %b",
                   it.tag, rdData, it.expReg, irq, it.expIrq);
        end
      end
    end
  end

  task automatic expectState(input logic [7:0] r, input logic i, input string tag);
    expItem_t it;
    it.expReg = r; it.expIrq = i; it.tag = tag;
    sbQueue.push_back(it);
    while (sbQueue.size() > 0) @(posedge clk);
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic srcEdges(input bit internalSrc, input int n);
    for (int e = 0; e < n; e++) begin
      @(negedge clk);
      if (internalSrc) intClk = 1'b1; else extClk = 1'b1;
      repeat (4) @(negedge clk);
      if (internalSrc) intClk = 1'b0; else extClk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expectState(8'h00, 1'b0, "R1 reset state");

    // R2: reserved bits read zero, ack bit not stored
    regWrite(8'hFF);
    expectState(8'h37, 1'b0, "R2 read layout");

    // R3 rate 1, external source, run mode
    powerMode = 2'b00;
    regWrite(8'h11);
    srcEdges(0, periodOf(1) - 1);
    expectState(8'h11, 1'b0, "R3 one edge short of period");
    srcEdges(0, 1);
    expectState(8'h91, 1'b1, "R3 flag at period, R8 irq");
    srcEdges(0, periodOf(1));
    expectState(8'h91, 1'b1, "R10 flag sticky");
    regWrite(8'h51);
    expectState(8'h11, 1'b0, "R7 ack clears flag");

    // R9: unchanged config keeps count
    srcEdges(0, 1);
    regWrite(8'h11);
    srcEdges(0, 1);
    expectState(8'h91, 1'b1, "R9 same-config write keeps count");
    regWrite(8'h51);

    // R9: rate change restarts
    srcEdges(0, 1);
    regWrite(8'h12);
    srcEdges(0, periodOf(2) - 1);
    expectState(8'h12, 1'b0, "R9 rate change restarts count");
    srcEdges(0, 1);
    expectState(8'h92, 1'b1, "R9 full period after restart");
    regWrite(8'h52);

    // R8: interrupt enable off
    regWrite(8'h01);
    srcEdges(0, periodOf(1));
    expectState(8'h81, 1'b0, "R8 irq masked");
    regWrite(8'h41);
    expectState(8'h01, 1'b0, "R7 ack with enable off");

    // R5: internal selected in run mode is frozen
    regWrite(8'h31);
    srcEdges(1, 3);
    srcEdges(0, 3);
    expectState(8'h31, 1'b0, "R5 internal frozen in run");

    // R6: stop mode uses internal
    powerMode = 2'b10;
    srcEdges(1, periodOf(1));
    expectState(8'hB1, 1'b1, "R6 internal counts in stop");
    regWrite(8'h71);
    srcEdges(0, 3);
    expectState(8'h31, 1'b0, "R6 external ignored in stop");
    powerMode = 2'b11;
    srcEdges(1, periodOf(1));
    expectState(8'hB1, 1'b1, "R6 stop encoding 11");
    regWrite(8'h71);

    // R6: external selected in stop is frozen
    powerMode = 2'b10;
    regWrite(8'h11);
    srcEdges(0, 3);
    srcEdges(1, 3);
    expectState(8'h11, 1'b0, "R6 external frozen in stop");

    // R5: wait mode counts external
    powerMode = 2'b01;
    srcEdges(0, periodOf(1));
    expectState(8'h91, 1'b1, "R5 external counts in wait");
    regWrite(8'h51);

    // R4: rate 0 disables
    powerMode = 2'b00;
    regWrite(8'h10);
    srcEdges(0, 10);
    expectState(8'h10, 1'b0, "R4 rate zero never expires");

    // R3: rate 3
    regWrite(8'h13);
    srcEdges(0, periodOf(3) - 1);
    expectState(8'h13, 1'b0, "R3 rate 3 short");
    srcEdges(0, 1);
    expectState(8'h93, 1'b1, "R3 rate 3 expires");

    // R3: rate 7 longest period, ack plus config change
    regWrite(8'h57);
    expectState(8'h17, 1'b0, "R7 ack with rate change");
    srcEdges(0, periodOf(7) - 1);
    expectState(8'h17, 1'b0, "R3 rate 7 short");
    srcEdges(0, 1);
    expectState(8'h97, 1'b1, "R3 rate 7 expires");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule